// File: doc/BRIEF.md
# Serial Interrupt Priority Chain

This block resolves interrupt priority among a parameterised number of devices. The devices are chained in series rather than fed to a parallel encoder. Each stage remembers a request from its device. All stages together drive a single interrupt line toward the processor, and that line works as a wired-OR of every pending request. When the processor answers with its acknowledge level, a priority token enters stage 0 and moves down the chain. A stage with nothing pending lets the token pass to the next stage. The first stage that holds a request keeps the token and drives its own vector constant onto the shared vector bus. Stage 0 is therefore the most urgent device, and each later stage is less urgent than the one before it.

The served request is cleared when acknowledge falls, so each device request is honoured once. A request that arrives while acknowledge is high does not disturb the grant in progress. It is parked in the stage and becomes eligible for the next acknowledge. Each stage reports with a one-cycle served pulse that it was the stage granted.

Top module: `irq_daisy_chain`

## Requirements
- R1: After synchronous reset, `cpu_irq_o` is 0, `bus_vec_o` is all zeros and `served_o` is all zeros.
- R2: A one-cycle high on bit k of `dev_req_i` is latched. From the next cycle, `cpu_irq_o` is 1, and it stays 1 until that request is served.
- R3: `cpu_irq_o` is the OR of the pending requests of all stages. It falls to 0 in the cycle after the last pending request is cleared.
- R4: While `cpu_ack_i` is 1, `bus_vec_o` carries in the same cycle the vector (bits k*VEC_W and up of `dev_vec_i`) of the lowest-index stage that holds a request.
- R5: A stage without a request passes the token on, so a higher-index stage is granted whenever every stage below its index is idle.
- R6: While no stage is granted, including during an acknowledge with no pending request, `bus_vec_o` is all zeros.
- R7: At most one stage is granted at any time. When several requests are pending, only the lowest-index one appears on the bus.
- R8: The granted stage clears its request on the first cycle with `cpu_ack_i` low after an acknowledge. In the cycle after that clock edge, `served_o` bit k is 1 for exactly one cycle.
- R9: A request that arrives while `cpu_ack_i` is 1 leaves the current grant and `bus_vec_o` unchanged. It is served on the following acknowledge.
- R10: A served request is not served again. The next acknowledge grants the next pending stage, or drives zeros if none is pending.
- R11: The vector input of a stage that is not granted has no effect on `bus_vec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_req_i | input | N_STAGES | Per-device request pulse; bit 0 has the highest priority |
| dev_vec_i | input | N_STAGES*VEC_W | Per-device vector constants; stage k uses bits [k*VEC_W +: VEC_W] |
| cpu_irq_o | output | 1 | Shared interrupt request to the processor, wired-OR of pending requests |
| cpu_ack_i | input | 1 | Acknowledge from the processor; drives priority-in of stage 0 |
| bus_vec_o | output | VEC_W | Shared vector bus, wired-OR of the enabled stage's vector |
| served_o | output | N_STAGES | One-cycle pulse per stage when its request is retired |

## Verification
A corrupted request flop in any stage shows on `cpu_irq_o` in the next cycle. On the next acknowledge it shows as a wrong or missing vector on `bus_vec_o`, in the same cycle the acknowledge rises. A broken token path shows as a low-priority vector winning, or as two vectors merged on the bus, in that same acknowledge cycle. A wrong clear or a wrong grant memory shows one cycle after acknowledge falls. It appears as a missing or misplaced `served_o` pulse, and afterwards as a repeated or skipped service on the following acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Token gating result for one stage
    typedef struct packed {
        logic po;   // token passed onward
        logic en;   // stage owns the vector bus
    } prio_gate_t;

    // Registered state held in each stage
    typedef struct packed {
        logic rf;       // request eligible for the next grant
        logic late;     // request parked while acknowledge is high
        logic grant;    // this stage held the token during the acknowledge
        logic served;   // one-cycle retire indication
    } stage_state_t;

    // Priority gate: a token is absorbed by a requesting stage
    function automatic prio_gate_t prio_gate(input logic pi, input logic rf);
        prio_gate_t g;
        g.po = pi & ~rf;
        g.en = pi & rf;
        return g;
    endfunction

endpackage

// File: rtl/irq_ack_edge.sv
module irq_ack_edge (
    input  logic clk,
    input  logic rst,
    input  logic ack_i,
    output logic fall_o
);
    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= ack_i;
    end

    assign fall_o = ack_q & ~ack_i;

endmodule

// File: rtl/irq_stage.sv
module irq_stage
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic ack_i,
    input  logic fall_i,
    input  logic pi_i,
    output logic po_o,
    output logic en_o,
    output logic pend_o,
    output logic served_o
);
    stage_state_t st;
    prio_gate_t   gate;

    always_comb gate = prio_gate(pi_i, st.rf);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (ack_i) begin
                // chain frozen: park new requests, remember the grant
                st.late  <= st.late | req_i;
                st.grant <= gate.en;
            end else begin
                st.rf    <= (st.rf & ~(fall_i & st.grant)) | st.late | req_i;
                st.late  <= 1'b0;
                if (fall_i) st.grant <= 1'b0;
            end
            st.served <= fall_i & st.grant;
        end
    end

    assign po_o     = gate.po;
    assign en_o     = gate.en;
    assign pend_o   = st.rf | st.late;
    assign served_o = st.served;

    // R2: a latched request persists until it is retired
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (st.rf && !(fall_i && st.grant)) |=> st.rf);

    // R8: the retire step clears the request when nothing new arrived
    assert_clear_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (fall_i && st.grant && !st.late && !req_i) |=> !st.rf);

    // R8: a served pulse only follows the falling acknowledge
    assert_served_after_fall_R8: assert property (@(posedge clk) disable iff (rst)
        served_o |-> $past(fall_i));

    // R9: the grant cannot move while acknowledge stays high
    assert_grant_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && $past(ack_i)) |-> $stable(en_o));

endmodule

// File: rtl/irq_wired_or.sv
module irq_wired_or #(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8
) (
    input  logic [N_STAGES-1:0]       en_i,
    input  logic [N_STAGES-1:0]       pend_i,
    input  logic [N_STAGES*VEC_W-1:0] vec_i,
    output logic                      irq_o,
    output logic [VEC_W-1:0]          vec_o
);
    logic [VEC_W-1:0] gated [N_STAGES];

    for (genvar k = 0; k < N_STAGES; k++) begin : g_gate
        assign gated[k] = en_i[k] ? vec_i[k*VEC_W +: VEC_W] : '0;
    end

    always_comb begin
        vec_o = '0;
        for (int k = 0; k < N_STAGES; k++) vec_o = vec_o | gated[k];
    end

    assign irq_o = |pend_i;

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_STAGES-1:0]       dev_req_i,
    input  logic [N_STAGES*VEC_W-1:0] dev_vec_i,
    output logic                      cpu_irq_o,
    input  logic                      cpu_ack_i,
    output logic [VEC_W-1:0]          bus_vec_o,
    output logic [N_STAGES-1:0]       served_o
);
    localparam int LAST = N_STAGES - 1;

    logic [N_STAGES:0]   token;
    logic [N_STAGES-1:0] en;
    logic [N_STAGES-1:0] pend;
    logic                ack_fall;

    irq_ack_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ack_i  (cpu_ack_i),
        .fall_o (ack_fall)
    );

    assign token[0] = cpu_ack_i;

    for (genvar k = 0; k <= LAST; k++) begin : g_stage
        irq_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .req_i    (dev_req_i[k]),
            .ack_i    (cpu_ack_i),
            .fall_i   (ack_fall),
            .pi_i     (token[k]),
            .po_o     (token[k+1]),
            .en_o     (en[k]),
            .pend_o   (pend[k]),
            .served_o (served_o[k])
        );
    end

    irq_wired_or #(
        .N_STAGES (N_STAGES),
        .VEC_W    (VEC_W)
    ) u_bus (
        .en_i   (en),
        .pend_i (pend),
        .vec_i  (dev_vec_i),
        .irq_o  (cpu_irq_o),
        .vec_o  (bus_vec_o)
    );

    // R7: the token is absorbed by at most one stage
    assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));

    // R6: with no stage enabled the bus floats to zero
    assert_idle_bus_R6: assert property (@(posedge clk) disable iff (rst)
        !(|en) |-> (bus_vec_o == '0));

    // R2: the request line only rises after a device request
    assert_irq_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_irq_o) |-> $past(|dev_req_i));

    // R8: at most one stage retires per acknowledge
    assert_single_serve_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(served_o));

endmodule

// File: tb/irq_daisy_chain_tb.sv
module irq_daisy_chain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int W  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N-1:0]     dev_req = '0;
    logic [N*W-1:0]   dev_vec;
    logic             cpu_irq;
    logic             cpu_ack = 1'b0;
    logic [W-1:0]     bus_vec;
    logic [N-1:0]     served;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_daisy_chain #(.N_STAGES(N), .VEC_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .dev_req_i (dev_req),
        .dev_vec_i (dev_vec),
        .cpu_irq_o (cpu_irq),
        .cpu_ack_i (cpu_ack),
        .bus_vec_o (bus_vec),
        .served_o  (served)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(posedge clk); #1 dev_req = m;
        @(posedge clk); #1 dev_req = '0;
    endtask

    // one acknowledge of one cycle, then check the retire pulse
    task automatic do_ack(input logic [W-1:0] exp_vec, input logic [N-1:0] exp_srv, input string tag);
        @(posedge clk); #1 cpu_ack = 1'b1;
        @(negedge clk); chk({tag, " vector"}, 32'(bus_vec), 32'(exp_vec));
        @(posedge clk); #1 cpu_ack = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({"R8 served pulse ", tag}, 32'(served), 32'(exp_srv));
        @(posedge clk); @(negedge clk);
        chk("R8 served one cycle", 32'(served), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 irq after reset", 32'(cpu_irq), 32'h0);
        chk("R1 bus after reset", 32'(bus_vec), 32'h0);
        chk("R1 served after reset", 32'(served), 32'h0);
    endtask

    task automatic t_single();
        pulse(4'b0010);
        @(negedge clk); chk("R2 irq set by pulse", 32'(cpu_irq), 32'h1);
        repeat (5) @(posedge clk);
        @(negedge clk); chk("R2 irq held", 32'(cpu_irq), 32'h1);
        do_ack(8'hB2, 4'b0010, "R5 R4 single stage1");
        chk("R3 irq cleared", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_none();
        do_ack(8'h00, 4'b0000, "R6 idle ack");
    endtask

    task automatic t_multi();
        pulse(4'b1010);
        @(negedge clk); chk("R3 irq multi", 32'(cpu_irq), 32'h1);
        do_ack(8'hB2, 4'b0010, "R7 lowest index wins");
        chk("R3 irq still pending", 32'(cpu_irq), 32'h1);
        do_ack(8'hD4, 4'b1000, "R10 next stage");
        do_ack(8'h00, 4'b0000, "R10 nothing left");
    endtask

    task automatic t_late();
        pulse(4'b0100);
        @(posedge clk); #1 cpu_ack = 1'b1;
        @(negedge clk); chk("R4 stage2 vector", 32'(bus_vec), 32'hC3);
        @(posedge clk); #1 dev_req = 4'b0001;
        @(posedge clk); #1 dev_req = '0;
        @(negedge clk); chk("R9 grant unchanged", 32'(bus_vec), 32'hC3);
        @(posedge clk); #1 cpu_ack = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 served stage2", 32'(served), 32'h4);
        chk("R9 late request pending", 32'(cpu_irq), 32'h1);
        do_ack(8'hA1, 4'b0001, "R9 late served");
    endtask

    task automatic t_vec_ignore();
        @(posedge clk); #1 dev_vec[0 +: W] = 8'h5A;
        @(negedge clk); chk("R11 idle bus ignores vector", 32'(bus_vec), 32'h0);
        pulse(4'b1000);
        @(posedge clk); #1 cpu_ack = 1'b1;
        @(negedge clk); chk("R11 only granted vector", 32'(bus_vec), 32'hD4);
        #1 dev_vec[W +: W] = 8'hFF;
        @(negedge clk); chk("R11 other vector changed", 32'(bus_vec), 32'hD4);
        @(posedge clk); #1 cpu_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R3 irq low at end", 32'(cpu_irq), 32'h0);
        dev_vec = {8'hD4, 8'hC3, 8'hB2, 8'hA1};
    endtask

    initial begin
        dev_vec = {8'hD4, 8'hC3, 8'hB2, 8'hA1};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_single();
        t_none();
        t_multi();
        t_late();
        t_vec_ignore();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        finish_run();
    end

endmodule